// File: doc/BRIEF.md
# Two-Phase Transaction Commit Sequencer

This per-core controller steps one hardware thread's transactions through their lifecycle. Instruction commands open a closed-nested or open-nested transaction level, validate it, commit it, or abort it explicitly. Commit takes two steps. A validate command first confirms that no conflict has reached the transaction since its outermost level began. From then on the transaction is shielded from rollback, and it is flagged as the winner to the conflict arbiter. A later commit command finishes the transaction and pulses a visibility strobe that releases its buffered writes.

Conflicts reported by the read/write-set tracker, and explicit aborts, divert control to a software monitor, much as a user-level interrupt does. While the monitor runs, further conflicts are only counted in a saturating counter and do not cause another entry. When the monitor signals return, any counted conflicts cause exactly one fresh entry. Otherwise the sequencer resumes the transaction or rolls back its innermost level, as the return-action input selects.

Top module: `txn_commit_seq`

## Requirements
- R1: After reset, status is IDLE (code 0), nest_depth is 0, and prio, mon_entry, commit_vis, err and pend_cnt are all 0.
- R2: Command code 1 (closed begin) or 2 (open begin) in IDLE, COMMITTED (3) or ABORTED (5) starts an outermost level: status becomes ACTIVE (1), nest_depth 0, and cur_open equals 1 only for code 2. In ACTIVE, the same codes push a nested level: nest_depth increments and cur_open records the new level's type. Once MAX_DEPTH levels exist, a further begin is an error.
- R3: Validate (code 3) in ACTIVE moves to VALIDATED (2) when no conflict has arrived since the outermost begin. Otherwise it enters the monitor (IN_MONITOR, code 4, with mon_entry). Resuming from the monitor does not forget that earlier conflict.
- R4: prio is 1 exactly while status is VALIDATED. A conflict in that state does not change status and raises no mon_entry.
- R5: Commit (code 4) in VALIDATED at depth 0 moves to COMMITTED and pulses commit_vis for one cycle. At depth above 0 it pops the level and returns to ACTIVE, and commit_vis pulses only if the popped level was open.
- R6: A conflict in ACTIVE, or abort (code 5) in ACTIVE, moves to IN_MONITOR, pulses mon_entry for one cycle and clears pend_cnt.
- R7: Each conflict cycle while IN_MONITOR increments pend_cnt, which saturates at 2^CNT_W-1, and raises no mon_entry.
- R8: A monitor-return strobe while IN_MONITOR with pend_cnt nonzero, or with a conflict in the same cycle, pulses mon_entry again, clears pend_cnt and stays IN_MONITOR.
- R9: A monitor-return strobe with nothing counted and ret_rollback 0 resumes to ACTIVE at the same depth. With ret_rollback 1 at depth 0 the status becomes ABORTED. At deeper levels it pops one level and returns to ACTIVE.
- R10: These are illegal and raise err for one cycle while status holds: commit outside VALIDATED; validate or abort outside ACTIVE; begin in VALIDATED or IN_MONITOR; any nonzero command while IN_MONITOR; codes 6 and 7; and a monitor-return strobe outside IN_MONITOR.
- R11: In ACTIVE, a conflict in the same cycle as a command takes precedence: the command is dropped without err and the monitor is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 none, 1 begin, 2 open begin, 3 validate, 4 commit, 5 abort) |
| conflict_in | input | 1 | Conflict report from the set tracker |
| mon_ret | input | 1 | Monitor-return strobe |
| ret_rollback | input | 1 | Return action: 0 resume, 1 roll back innermost level |
| status | output | 3 | Transaction status code |
| prio | output | 1 | Priority flag to the conflict arbiter |
| mon_entry | output | 1 | One-cycle monitor-entry request |
| pend_cnt | output | CNT_W | Conflicts counted during monitor handling |
| commit_vis | output | 1 | One-cycle write-visibility pulse |
| err | output | 1 | One-cycle illegal-command flag |
| nest_depth | output | $clog2(MAX_DEPTH) | Index of the innermost active level |
| cur_open | output | 1 | Innermost level is open-nested |

## Verification
A corrupted state register shows up on the status code in the cycle after the faulty edge. It also shows up one cycle after the next command, which then produces the wrong err, mon_entry or commit_vis for the legal-command table. A lost conflict-seen flag surfaces only at the next validate, which reaches VALIDATED when it should have entered the monitor. A wrong nesting record surfaces at the inner commit, as a missing or spurious commit_vis. The bench sweeps every command code from every status and covers all open/closed patterns across the full nesting depth, so each of these faults is exposed within a few cycles of the stimulus.

// File: rtl/txn_seq_pkg.sv
package txn_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_ACTIVE    = 3'd1,
      ST_VALIDATED = 3'd2,
      ST_COMMITTED = 3'd3,
      ST_IN_MON    = 3'd4,
      ST_ABORTED   = 3'd5
   } txn_st_e;

   typedef enum logic [2:0] {
      OP_NOP      = 3'd0,
      OP_BEGIN    = 3'd1,
      OP_BEGIN_OP = 3'd2,
      OP_VALIDATE = 3'd3,
      OP_COMMIT   = 3'd4,
      OP_ABORT    = 3'd5,
      OP_RSV6     = 3'd6,
      OP_RSV7     = 3'd7
   } txn_op_e;

endpackage

// File: rtl/txn_nest_stack.sv
module txn_nest_stack #(
   parameter int MAX_DEPTH = 4,
   localparam int DW = $clog2(MAX_DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          outer_start,
   input  logic          push,
   input  logic          pop,
   input  logic          lvl_open,
   output logic [DW-1:0] depth,
   output logic          full,
   output logic          top_open
);

   localparam logic [DW-1:0] LAST = DW'(MAX_DEPTH - 1);

   logic [DW-1:0]        depth_q;
   logic [MAX_DEPTH-1:0] open_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           depth_q <= '0;
      else if (outer_start) depth_q <= '0;
      else if (push)        depth_q <= depth_q + 1'b1;
      else if (pop)         depth_q <= depth_q - 1'b1;
   end

   for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_lvl
      localparam logic [DW-1:0] IDX = DW'(g);
      logic wr;
      if (g == 0) begin : g_root
         assign wr = outer_start;
      end else begin : g_inner
         assign wr = push && !outer_start && (depth_q + 1'b1 == IDX);
      end
      always_ff @(posedge clk) begin
         if (!rst_n)  open_q[g] <= 1'b0;
         else if (wr) open_q[g] <= lvl_open;
      end
   end

   assign depth    = depth_q;
   assign full     = (depth_q == LAST);
   assign top_open = open_q[depth_q];

endmodule

// File: rtl/txn_pend_ctr.sv
module txn_pend_ctr #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             nz
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clr)                  cnt_q <= '0;
      else if (inc && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;
   assign nz  = |cnt_q;

endmodule

// File: rtl/txn_seq_fsm.sv
module txn_seq_fsm
   import txn_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_op,
   input  logic       conflict_in,
   input  logic       mon_ret,
   input  logic       ret_rollback,
   input  logic       depth_zero,
   input  logic       depth_full,
   input  logic       top_open,
   input  logic       cnt_nz,
   output logic [2:0] status,
   output logic       prio,
   output logic       commit_vis,
   output logic       mon_entry,
   output logic       err,
   output logic       stk_outer,
   output logic       stk_push,
   output logic       stk_pop,
   output logic       stk_open,
   output logic       cnt_inc,
   output logic       cnt_clr
);

   txn_st_e state_q, state_d;
   logic    seen_q, seen_d;
   logic    err_q, err_d;
   logic    vis_q, vis_d;
   logic    ent_q, ent_d;
   txn_op_e op;
   logic    is_begin;

   always_comb begin
      op        = cmd_valid ? txn_op_e'(cmd_op) : OP_NOP;
      is_begin  = (op == OP_BEGIN) || (op == OP_BEGIN_OP);
      stk_open  = (op == OP_BEGIN_OP);
      state_d   = state_q;
      seen_d    = seen_q;
      err_d     = mon_ret && (state_q != ST_IN_MON);
      vis_d     = 1'b0;
      ent_d     = 1'b0;
      stk_outer = 1'b0;
      stk_push  = 1'b0;
      stk_pop   = 1'b0;
      cnt_inc   = 1'b0;
      cnt_clr   = 1'b0;
      unique case (state_q)
         ST_ACTIVE: begin
            if (conflict_in) begin
               state_d = ST_IN_MON;
               ent_d   = 1'b1;
               cnt_clr = 1'b1;
               seen_d  = 1'b1;
            end else begin
               unique case (op)
                  OP_NOP: ;
                  OP_BEGIN, OP_BEGIN_OP: begin
                     if (depth_full) err_d = 1'b1;
                     else            stk_push = 1'b1;
                  end
                  OP_VALIDATE: begin
                     if (seen_q) begin
                        state_d = ST_IN_MON;
                        ent_d   = 1'b1;
                        cnt_clr = 1'b1;
                     end else begin
                        state_d = ST_VALIDATED;
                     end
                  end
                  OP_ABORT: begin
                     state_d = ST_IN_MON;
                     ent_d   = 1'b1;
                     cnt_clr = 1'b1;
                  end
                  default: err_d = 1'b1;
               endcase
            end
         end
         ST_VALIDATED: begin
            if (op == OP_COMMIT) begin
               vis_d = depth_zero || top_open;
               if (depth_zero) begin
                  state_d = ST_COMMITTED;
               end else begin
                  stk_pop = 1'b1;
                  state_d = ST_ACTIVE;
               end
            end else if (op != OP_NOP) begin
               err_d = 1'b1;
            end
         end
         ST_IN_MON: begin
            if (op != OP_NOP) err_d = 1'b1;
            if (mon_ret) begin
               if (cnt_nz || conflict_in) begin
                  ent_d   = 1'b1;
                  cnt_clr = 1'b1;
               end else if (ret_rollback) begin
                  seen_d = 1'b0;
                  if (depth_zero) begin
                     state_d = ST_ABORTED;
                  end else begin
                     stk_pop = 1'b1;
                     state_d = ST_ACTIVE;
                  end
               end else begin
                  state_d = ST_ACTIVE;
               end
            end else if (conflict_in) begin
               cnt_inc = 1'b1;
            end
         end
         default: begin
            if (is_begin) begin
               stk_outer = 1'b1;
               state_d   = ST_ACTIVE;
               seen_d    = 1'b0;
            end else if (op != OP_NOP) begin
               err_d = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         seen_q  <= 1'b0;
         err_q   <= 1'b0;
         vis_q   <= 1'b0;
         ent_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         seen_q  <= seen_d;
         err_q   <= err_d;
         vis_q   <= vis_d;
         ent_q   <= ent_d;
      end
   end

   assign status     = state_q;
   assign prio       = (state_q == ST_VALIDATED);
   assign commit_vis = vis_q;
   assign mon_entry  = ent_q;
   assign err        = err_q;

endmodule

// File: rtl/txn_commit_seq.sv
module txn_commit_seq #(
   parameter int MAX_DEPTH = 4,
   parameter int CNT_W = 3,
   localparam int DW = $clog2(MAX_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic             conflict_in,
   input  logic             mon_ret,
   input  logic             ret_rollback,
   output logic [2:0]       status,
   output logic             prio,
   output logic             mon_entry,
   output logic [CNT_W-1:0] pend_cnt,
   output logic             commit_vis,
   output logic             err,
   output logic [DW-1:0]    nest_depth,
   output logic             cur_open
);

   if (MAX_DEPTH < 2 || (1 << DW) != MAX_DEPTH) begin : g_bad_depth
      $error("MAX_DEPTH must be a power of two of at least 2");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 1..16");
   end

   logic s_outer, s_push, s_pop, s_open;
   logic s_full, s_top_open;
   logic c_inc, c_clr, c_nz;
   logic [DW-1:0] s_depth;

   txn_nest_stack #(.MAX_DEPTH(MAX_DEPTH)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .outer_start(s_outer),
      .push       (s_push),
      .pop        (s_pop),
      .lvl_open   (s_open),
      .depth      (s_depth),
      .full       (s_full),
      .top_open   (s_top_open)
   );

   txn_pend_ctr #(.CNT_W(CNT_W)) u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (c_clr),
      .inc  (c_inc),
      .cnt  (pend_cnt),
      .nz   (c_nz)
   );

   txn_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_op      (cmd_op),
      .conflict_in (conflict_in),
      .mon_ret     (mon_ret),
      .ret_rollback(ret_rollback),
      .depth_zero  (s_depth == '0),
      .depth_full  (s_full),
      .top_open    (s_top_open),
      .cnt_nz      (c_nz),
      .status      (status),
      .prio        (prio),
      .commit_vis  (commit_vis),
      .mon_entry   (mon_entry),
      .err         (err),
      .stk_outer   (s_outer),
      .stk_push    (s_push),
      .stk_pop     (s_pop),
      .stk_open    (s_open),
      .cnt_inc     (c_inc),
      .cnt_clr     (c_clr)
   );

   assign nest_depth = s_depth;
   assign cur_open   = s_top_open;

endmodule

// File: rtl/txn_seq_chk.sv
module txn_seq_chk #(
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic             conflict_in,
   input logic             mon_ret,
   input logic [2:0]       status,
   input logic             prio,
   input logic             mon_entry,
   input logic [CNT_W-1:0] pend_cnt,
   input logic             commit_vis,
   input logic             err
);

   localparam logic [2:0] S_ACT = 3'd1;
   localparam logic [2:0] S_VAL = 3'd2;
   localparam logic [2:0] S_MON = 3'd4;
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   a_r5_vis_after_validated: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vis |-> $past(status) == S_VAL);

   a_r4_validated_not_rolled: assert property (@(posedge clk) disable iff (!rst_n)
      (status == S_VAL && conflict_in && !(cmd_valid && cmd_op == 3'd4)) |=> status == S_VAL);

   a_r4_prio_from_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prio) |-> $past(status) == S_ACT);

   a_r7_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      (status == S_MON && conflict_in && !mon_ret) |=> (!mon_entry && status == S_MON));

   a_r6_entry_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
      mon_entry |-> pend_cnt == '0);

   a_r7_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (status == S_MON && pend_cnt == TOP && !mon_ret) |=> pend_cnt == TOP);

   a_r10_err_holds_status: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($stable(status) || $past(mon_ret)));

   a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({commit_vis, mon_entry}));

endmodule

bind txn_commit_seq txn_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .conflict_in(conflict_in),
   .mon_ret    (mon_ret),
   .status     (status),
   .prio       (prio),
   .mon_entry  (mon_entry),
   .pend_cnt   (pend_cnt),
   .commit_vis (commit_vis),
   .err        (err)
);

// File: tb/txn_commit_seq_tb.sv
module txn_commit_seq_tb;

   localparam int MAXD = 4;
   localparam int CW   = 2;
   localparam int DW   = $clog2(MAXD);
   localparam int SAT  = (1 << CW) - 1;

   localparam int IDLE = 0, ACT = 1, VAL = 2, COMM = 3, MON = 4, ABRT = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic conflict_in = 1'b0;
   logic mon_ret = 1'b0;
   logic ret_rollback = 1'b0;
   logic [2:0] status;
   logic prio, mon_entry, commit_vis, err, cur_open;
   logic [CW-1:0] pend_cnt;
   logic [DW-1:0] nest_depth;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   txn_commit_seq #(.MAX_DEPTH(MAXD), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .conflict_in(conflict_in), .mon_ret(mon_ret), .ret_rollback(ret_rollback),
      .status(status), .prio(prio), .mon_entry(mon_entry), .pend_cnt(pend_cnt),
      .commit_vis(commit_vis), .err(err), .nest_depth(nest_depth), .cur_open(cur_open)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one clock: drive at the falling edge, sample just after the rising edge
   task automatic cyc(input logic v, input int op, input logic c, input logic r, input logic rb);
      @(negedge clk);
      cmd_valid    = v;
      cmd_op       = 3'(op);
      conflict_in  = c;
      mon_ret      = r;
      ret_rollback = rb;
      @(posedge clk);
      #2;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0; conflict_in = 1'b0; mon_ret = 1'b0; ret_rollback = 1'b0;
   endtask

   task automatic cmd(input int op);
      cyc(1'b1, op, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic go_state(input int s);
      do_reset();
      case (s)
         ACT:  cmd(1);
         VAL:  begin cmd(1); cmd(3); end
         COMM: begin cmd(1); cmd(3); cmd(4); end
         MON:  begin cmd(1); cmd(5); end
         ABRT: begin cmd(1); cmd(5); cyc(1'b0, 0, 1'b0, 1'b1, 1'b1); end
         default: ;
      endcase
   endtask

   // expected reaction of the command table, depth 0, nothing pending
   function automatic int exp_next(input int s, input int op);
      case (s)
         ACT: case (op)
                 3: return VAL;
                 5: return MON;
                 default: return ACT;
              endcase
         VAL: return (op == 4) ? COMM : VAL;
         MON: return MON;
         default: return (op == 1 || op == 2) ? ACT : s;
      endcase
   endfunction

   function automatic int exp_err(input int s, input int op);
      if (op == 0) return 0;
      case (s)
         ACT: return (op == 4 || op >= 6) ? 1 : 0;
         VAL: return (op == 4) ? 0 : 1;
         MON: return 1;
         default: return (op == 1 || op == 2) ? 0 : 1;
      endcase
   endfunction

   initial begin
      #3_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int ex_depth;
      do_reset();
      // R1 reset state
      #1;
      chk("R1", "status", status, IDLE);
      chk("R1", "depth", nest_depth, 0);
      chk("R1", "prio", prio, 0);
      chk("R1", "mon_entry", mon_entry, 0);
      chk("R1", "commit_vis", commit_vis, 0);
      chk("R1", "err", err, 0);
      chk("R1", "pend_cnt", pend_cnt, 0);

      // R10 sweep: every command from every status
      for (int s = 0; s < 6; s++) begin
         for (int op = 0; op < 8; op++) begin
            go_state(s);
            cmd(op);
            chk("R10", $sformatf("status s%0d op%0d", s, op), status, exp_next(s, op));
            chk("R10", $sformatf("err s%0d op%0d", s, op), err, exp_err(s, op));
            chk("R6", $sformatf("mon_entry s%0d op%0d", s, op), mon_entry,
                (s == ACT && op == 5) ? 1 : 0);
            chk("R5", $sformatf("commit_vis s%0d op%0d", s, op), commit_vis,
                (s == VAL && op == 4) ? 1 : 0);
            chk("R4", $sformatf("prio s%0d op%0d", s, op), prio,
                (exp_next(s, op) == VAL) ? 1 : 0);
         end
      end

      // R10 monitor-return outside the monitor
      go_state(ACT);
      cyc(1'b0, 0, 1'b0, 1'b1, 1'b0);
      chk("R10", "stray return err", err, 1);
      chk("R10", "stray return status", status, ACT);

      // R2 and R5: every open/closed pattern over the full depth
      for (int pat = 0; pat < (1 << MAXD); pat++) begin
         do_reset();
         for (int l = 0; l < MAXD; l++) begin
            cmd(((pat >> l) & 1) ? 2 : 1);
            chk("R2", $sformatf("depth p%0d l%0d", pat, l), nest_depth, l);
            chk("R2", $sformatf("type p%0d l%0d", pat, l), cur_open, (pat >> l) & 1);
            chk("R2", "begin err", err, 0);
         end
         cmd(1);
         chk("R2", "begin beyond depth err", err, 1);
         chk("R2", "depth kept", nest_depth, MAXD - 1);
         for (int l = MAXD - 1; l >= 0; l--) begin
            cmd(3);
            chk("R3", "inner validate", status, VAL);
            cmd(4);
            chk("R5", $sformatf("vis p%0d l%0d", pat, l), commit_vis,
                (l == 0) ? 1 : ((pat >> l) & 1));
            chk("R5", $sformatf("status p%0d l%0d", pat, l), status, (l == 0) ? COMM : ACT);
            ex_depth = (l == 0) ? 0 : l - 1;
            chk("R5", "depth after commit", nest_depth, ex_depth);
         end
      end

      // R3 and R11: conflict remembered across resume; conflict beats a command
      do_reset();
      cmd(1);
      cyc(1'b1, 3, 1'b1, 1'b0, 1'b0);
      chk("R11", "conflict wins status", status, MON);
      chk("R11", "dropped command no err", err, 0);
      chk("R6", "entry on conflict", mon_entry, 1);
      cyc(1'b0, 0, 1'b0, 1'b1, 1'b0);
      chk("R9", "resume", status, ACT);
      cmd(3);
      chk("R3", "validate fails after conflict", status, MON);
      chk("R3", "validate failure entry", mon_entry, 1);
      cyc(1'b0, 0, 1'b0, 1'b1, 1'b1);
      chk("R9", "rollback depth0", status, ABRT);
      cmd(2);
      cmd(3);
      chk("R3", "fresh begin validates", status, VAL);

      // R4: conflicts cannot disturb a validated transaction
      for (int k = 0; k < 3; k++) begin
         cyc(1'b0, 0, 1'b1, 1'b0, 1'b0);
         chk("R4", "validated holds", status, VAL);
         chk("R4", "no entry", mon_entry, 0);
         chk("R4", "prio", prio, 1);
      end
      cmd(4);
      chk("R5", "commit after conflicts", commit_vis, 1);
      chk("R4", "prio drops", prio, 0);

      // R7 and R8: counting during the monitor, saturation, single re-entry
      for (int k = 0; k < 6; k++) begin
         do_reset();
         cmd(1);
         cmd(5);
         chk("R6", "abort entry", mon_entry, 1);
         for (int i = 1; i <= k; i++) begin
            cyc(1'b0, 0, 1'b1, 1'b0, 1'b0);
            chk("R7", $sformatf("count k%0d i%0d", k, i), pend_cnt, (i > SAT) ? SAT : i);
            chk("R7", "no re-entry", mon_entry, 0);
         end
         cyc(1'b0, 0, 1'b0, 1'b1, 1'b0);
         chk("R8", $sformatf("return entry k%0d", k), mon_entry, (k > 0) ? 1 : 0);
         chk("R8", "return status", status, (k > 0) ? MON : ACT);
         chk("R8", "count cleared", pend_cnt, 0);
         if (k > 0) begin
            cyc(1'b0, 0, 1'b0, 1'b1, 1'b0);
            chk("R9", "second return resumes", status, ACT);
         end
      end
      // R8: conflict in the return cycle
      do_reset();
      cmd(1);
      cmd(5);
      cyc(1'b0, 0, 1'b1, 1'b1, 1'b0);
      chk("R8", "same-cycle conflict re-enters", mon_entry, 1);
      chk("R8", "stays in monitor", status, MON);

      // R9: nested rollback and resume keep or pop depth
      do_reset();
      cmd(1);
      cmd(2);
      cmd(1);
      cmd(5);
      cyc(1'b0, 0, 1'b0, 1'b1, 1'b0);
      chk("R9", "resume keeps depth", nest_depth, 2);
      cmd(5);
      cyc(1'b0, 0, 1'b0, 1'b1, 1'b1);
      chk("R9", "rollback pops", nest_depth, 1);
      chk("R9", "rollback status", status, ACT);
      chk("R9", "level below is open", cur_open, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule